// File: doc/BRIEF.md
# Quadrature encoder input decoder

This block sits between two raw encoder pins, phase A and phase B, and a position counter. It turns pin activity into a one-cycle count strobe and a direction bit, which the counter consumes on the next clock. Everything runs on the system clock with a synchronous, active-high reset. The counter and any register access are outside this block.

A two-bit scale selector chooses between two modes. In the three quadrature settings, both pins pass through a synchroniser and a stable-sample filter. The filtered pair is then decoded as a Gray-code sequence at one, two or four counts per encoder cycle. In clock-and-direction mode the filter and decoder are bypassed: a rising edge on synchronised A produces one count, and the level on synchronised B gives its direction.

An enable input gates the pins. A sticky noise flag records any step in which both filtered phases change together, which is not a legal Gray-code step. The flag stays set until an explicit clear strobe arrives.

Top module: `quad_input_decoder`

## Requirements
- R1: While reset is high, and on the first cycle after it, `countStrobe`, `countUp` and `noiseError` are 0. All synchroniser, filter and history state resets to 0.
- R2: The enable input is registered, and its registered copy is 0 after reset. While that copy is 0, no count strobe is produced and `noiseError` is not set, whatever the pins do.
- R3: With `scaleMode` = 0 (clock-and-direction), one strobe is produced for each rising edge of synchronised A. `countUp` equals synchronised B, so B = 1 counts up and B = 0 counts down. The filter is not applied in this mode.
- R4: With `scaleMode` = 3 (x4), every legal single-phase step of the filtered pair produces one strobe. A step forward in the order (A,B) = 00, 10, 11, 01, 00 gives `countUp` = 1, and a step backward gives 0. Each strobe lasts one cycle, and `countUp` is 0 whenever no strobe is present.
- R5: With `scaleMode` = 2 (x2), only legal steps in which filtered A changes produce a strobe. That is two counts per encoder cycle, with the direction as in R4.
- R6: With `scaleMode` = 1 (x1), only a legal change of filtered A while filtered B is 0 produces a strobe. That is one count per encoder cycle, with the direction as in R4.
- R7: In the quadrature modes, a filtered phase takes a new value only after FILT_TAPS consecutive synchronised samples agree on it. A pulse shorter than that produces no strobe.
- R8: In a quadrature mode, a step in which both filtered phases change at once produces no strobe and sets `noiseError`. The flag stays set until `errClear` is sampled high. If a new error and a clear arrive in the same cycle, the error wins.
- R9: With `scaleMode` = 0, `noiseError` is never set, even when A and B change together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| encA | input | 1 | Raw encoder phase A (count clock in clock-and-direction mode) |
| encB | input | 1 | Raw encoder phase B (direction level in clock-and-direction mode) |
| abEnable | input | 1 | Pin enable; 0 suppresses counts and noise detection |
| scaleMode | input | 2 | 0 clock-and-direction, 1 x1, 2 x2, 3 x4 |
| errClear | input | 1 | Clears the sticky noise flag |
| countStrobe | output | 1 | One-cycle request to count |
| countUp | output | 1 | Direction for the current strobe (1 = up) |
| noiseError | output | 1 | Sticky illegal-transition flag |

## Verification
If the stored filtered pair or the previous-sample history is wrong, the effect shows at the ports about six cycles after the pin change: a strobe is missing or extra, or `countUp` has the wrong polarity. A fault in the noise path appears as `noiseError` rising without cause, or failing to hold, on the cycle after the bad step or after the clear. Because the bench compares every output on every clock, a one-cycle latency shift is reported at the first strobe. Per-phase totals of up and down strobes catch scale-selection faults that keep the timing intact.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  localparam int ENC_CH = 2;

  typedef enum logic [1:0] {
    MODE_CLKDIR = 2'd0,
    MODE_X1     = 2'd1,
    MODE_X2     = 2'd2,
    MODE_X4     = 2'd3
  } scale_e;

  typedef struct packed {
    logic a;
    logic b;
  } ab_t;

  typedef struct packed {
    logic emitCount;
    logic emitUp;
    logic raiseNoise;
  } strobes_t;
endpackage

// File: rtl/qdec_datapath.sv
module qdec_datapath
  import qdec_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     encA,
  input  logic     encB,
  input  logic     abEnable,
  input  logic     errClear,
  input  strobes_t strb,
  output ab_t      curAB,
  output ab_t      prevAB,
  output ab_t      syncAB,
  output logic     prevSyncA,
  output logic     enReg,
  output logic     countStrobe,
  output logic     countUp,
  output logic     noiseError
);
  localparam int SYNC_MSB = SYNC_STAGES - 1;
  localparam int TAP_MSB  = FILT_TAPS - 1;

  logic [ENC_CH-1:0] rawVec;
  logic [ENC_CH-1:0] syncVec;
  logic [ENC_CH-1:0] filtVec;
  logic [ENC_CH-1:0] prevFiltVec;

  assign rawVec = {encB, encA};

  // Per-phase synchroniser, stable-sample filter and history flop.
  for (genvar ch = 0; ch < ENC_CH; ch++) begin : g_phase
    logic [SYNC_MSB:0] syncChain;
    logic [TAP_MSB:0]  sampleWin;
    logic              filtQ;
    logic              prevFiltQ;

    always_ff @(posedge clk) begin
      if (rst) begin
        syncChain <= '0;
        sampleWin <= '0;
        filtQ     <= 1'b0;
        prevFiltQ <= 1'b0;
      end else begin
        syncChain <= {syncChain[SYNC_MSB-1:0], rawVec[ch]};
        sampleWin <= {sampleWin[TAP_MSB-1:0], syncChain[SYNC_MSB]};
        if (&sampleWin)       filtQ <= 1'b1;
        else if (~|sampleWin) filtQ <= 1'b0;
        prevFiltQ <= filtQ;
      end
    end

    assign syncVec[ch]     = syncChain[SYNC_MSB];
    assign filtVec[ch]     = filtQ;
    assign prevFiltVec[ch] = prevFiltQ;
  end

  assign curAB  = '{a: filtVec[0],     b: filtVec[1]};
  assign prevAB = '{a: prevFiltVec[0], b: prevFiltVec[1]};
  assign syncAB = '{a: syncVec[0],     b: syncVec[1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      prevSyncA   <= 1'b0;
      enReg       <= 1'b0;
      countStrobe <= 1'b0;
      countUp     <= 1'b0;
      noiseError  <= 1'b0;
    end else begin
      prevSyncA   <= syncVec[0];
      enReg       <= abEnable;
      countStrobe <= strb.emitCount;
      countUp     <= strb.emitCount & strb.emitUp;
      noiseError  <= strb.raiseNoise | (noiseError & ~errClear);
    end
  end

  // Assertions beside the output registers they guard.
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!countStrobe && !countUp && !noiseError));

  p_noise_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (noiseError && !errClear) |=> noiseError);

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    countStrobe |=> !countStrobe);

  p_dir_with_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    countUp |-> countStrobe);
endmodule

// File: rtl/qdec_control.sv
module qdec_control
  import qdec_pkg::*;
(
  input  scale_e   mode,
  input  logic     enReg,
  input  ab_t      curAB,
  input  ab_t      prevAB,
  input  ab_t      syncAB,
  input  logic     prevSyncA,
  output strobes_t strb
);
  logic aMoved;
  logic bMoved;
  logic oneStep;
  logic twoStep;
  logic fwd;
  logic quadSel;

  always_comb begin
    aMoved  = curAB.a ^ prevAB.a;
    bMoved  = curAB.b ^ prevAB.b;
    oneStep = aMoved ^ bMoved;
    twoStep = aMoved & bMoved;
    // A moving forward leaves A != B; B moving forward makes B follow A.
    fwd     = aMoved ? (curAB.a ^ curAB.b) : ~(curAB.a ^ curAB.b);
    quadSel = (mode != MODE_CLKDIR);

    strb = '0;
    case (mode)
      MODE_CLKDIR: begin
        strb.emitCount = enReg & syncAB.a & ~prevSyncA;
        strb.emitUp    = syncAB.b;
      end
      MODE_X1: begin
        strb.emitCount = enReg & oneStep & aMoved & ~curAB.b;
        strb.emitUp    = fwd;
      end
      MODE_X2: begin
        strb.emitCount = enReg & oneStep & aMoved;
        strb.emitUp    = fwd;
      end
      default: begin
        strb.emitCount = enReg & oneStep;
        strb.emitUp    = fwd;
      end
    endcase
    strb.raiseNoise = enReg & twoStep & quadSel;
  end
endmodule

// File: rtl/quad_input_decoder.sv
module quad_input_decoder
  import qdec_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       encA,
  input  logic       encB,
  input  logic       abEnable,
  input  logic [1:0] scaleMode,
  input  logic       errClear,
  output logic       countStrobe,
  output logic       countUp,
  output logic       noiseError
);
  scale_e   modeSel;
  strobes_t strb;
  ab_t      curAB;
  ab_t      prevAB;
  ab_t      syncAB;
  logic     prevSyncA;
  logic     enReg;

  assign modeSel = scale_e'(scaleMode);

  qdec_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_TAPS  (FILT_TAPS)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .encA       (encA),
    .encB       (encB),
    .abEnable   (abEnable),
    .errClear   (errClear),
    .strb       (strb),
    .curAB      (curAB),
    .prevAB     (prevAB),
    .syncAB     (syncAB),
    .prevSyncA  (prevSyncA),
    .enReg      (enReg),
    .countStrobe(countStrobe),
    .countUp    (countUp),
    .noiseError (noiseError)
  );

  qdec_control u_ctl (
    .mode     (modeSel),
    .enReg    (enReg),
    .curAB    (curAB),
    .prevAB   (prevAB),
    .syncAB   (syncAB),
    .prevSyncA(prevSyncA),
    .strb     (strb)
  );

  p_gate_count_r2: assert property (@(posedge clk) disable iff (rst)
    !abEnable |-> ##2 !countStrobe);

  p_gate_noise_r2: assert property (@(posedge clk) disable iff (rst)
    !abEnable |-> ##2 !$rose(noiseError));

  p_clkdir_no_noise_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(noiseError) |-> ($past(scaleMode) != 2'd0));

  p_x2_a_only_r5: assert property (@(posedge clk) disable iff (rst)
    (countStrobe && $past(scaleMode) == 2'd2) |-> $past(curAB.a != prevAB.a));

  p_filtered_step_r7: assert property (@(posedge clk) disable iff (rst)
    (countStrobe && $past(scaleMode) != 2'd0) |-> $past(curAB != prevAB));
endmodule

// File: tb/sim_quad_input_decoder.sv
`timescale 1ns/1ps
module sim_quad_input_decoder;
  localparam int SYNC = 2;
  localparam int TAPS = 3;
  localparam int MAXT = 8192;
  localparam int OFS  = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       encA = 1'b0;
  logic       encB = 1'b0;
  logic       abEnable = 1'b0;
  logic [1:0] scaleMode = 2'd0;
  logic       errClear = 1'b0;
  logic       countStrobe;
  logic       countUp;
  logic       noiseError;

  quad_input_decoder u0 (
    .clk(clk), .rst(rst), .encA(encA), .encB(encB), .abEnable(abEnable),
    .scaleMode(scaleMode), .errClear(errClear),
    .countStrobe(countStrobe), .countUp(countUp), .noiseError(noiseError)
  );

  always #2 clk = ~clk;

  // Recorded inputs per clock edge and modelled filtered phases.
  bit rA [MAXT];
  bit rB [MAXT];
  bit rEn[MAXT];
  bit rClr[MAXT];
  int rMode[MAXT];
  bit fA [MAXT];
  bit fB [MAXT];
  int t = OFS;
  bit expS, expU, expN;
  int nChecks = 0;
  int nFails  = 0;
  string tag = "R1";
  int upSeen = 0;
  int dnSeen = 0;
  int posNow = 0;

  function automatic int gpos(bit a, bit b);
    case ({a, b})
      2'b00:   return 0;
      2'b10:   return 1;
      2'b11:   return 2;
      default: return 3;
    endcase
  endfunction

  // Reference model: one step per rising edge.
  always @(posedge clk) begin
    bit all1A, all0A, all1B, all0B, aCh, s, u, e;
    int d, m;
    if (t < MAXT - 1) t++;
    rA[t] = encA; rB[t] = encB; rEn[t] = abEnable;
    rClr[t] = errClear; rMode[t] = int'(scaleMode);
    if (rst) begin
      fA[t] = 0; fB[t] = 0; expS = 0; expU = 0; expN = 0;
    end else begin
      all1A = 1; all0A = 1; all1B = 1; all0B = 1;
      for (int j = 0; j < TAPS; j++) begin
        if (rA[t-1-SYNC-j]) all0A = 0; else all1A = 0;
        if (rB[t-1-SYNC-j]) all0B = 0; else all1B = 0;
      end
      fA[t] = all1A ? 1'b1 : (all0A ? 1'b0 : fA[t-1]);
      fB[t] = all1B ? 1'b1 : (all0B ? 1'b0 : fB[t-1]);
      d   = (gpos(fA[t-1], fB[t-1]) - gpos(fA[t-2], fB[t-2]) + 4) % 4;
      aCh = (fA[t-1] != fA[t-2]);
      e   = rEn[t-1];
      m   = rMode[t];
      s = 0; u = 0;
      if (e) begin
        case (m)
          0: if (rA[t-SYNC] && !rA[t-SYNC-1]) begin s = 1; u = rB[t-SYNC]; end
          1: if (aCh && d != 2 && !fB[t-1]) begin s = 1; u = (d == 1); end
          2: if (aCh && d != 2) begin s = 1; u = (d == 1); end
          default: if (d == 1 || d == 3) begin s = 1; u = (d == 1); end
        endcase
      end
      expN = (e && m != 0 && d == 2) || (expN && !rClr[t]);
      expS = s;
      expU = s & u;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, t);
    end
  endtask

  // Per-cycle comparison and strobe tallies, away from the active edge.
  always @(negedge clk) begin
    if (t > OFS) begin
      chk(tag, "countStrobe", int'(countStrobe), int'(expS));
      chk(tag, "countUp", int'(countUp), int'(expU));
      chk(tag, "noiseError", int'(noiseError), int'(expN));
    end
    if (countStrobe && countUp)  upSeen++;
    if (countStrobe && !countUp) dnSeen++;
  end

  task automatic setAB(bit a, bit b, int hold);
    @(negedge clk);
    encA = a; encB = b;
    repeat (hold - 1) @(negedge clk);
  endtask

  task automatic rotate(int cycles, bit fwd);
    for (int i = 0; i < cycles * 4; i++) begin
      posNow = fwd ? (posNow + 1) % 4 : (posNow + 3) % 4;
      case (posNow)
        0: setAB(0, 0, 6);
        1: setAB(1, 0, 6);
        2: setAB(1, 1, 6);
        default: setAB(0, 1, 6);
      endcase
    end
  endtask

  task automatic settleClear();
    repeat (12) @(negedge clk);
    upSeen = 0; dnSeen = 0;
  endtask

  task automatic tally(string req, int wantUp, int wantDn);
    repeat (12) @(negedge clk);
    chk(req, "up total", upSeen, wantUp);
    chk(req, "down total", dnSeen, wantDn);
    upSeen = 0; dnSeen = 0;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired at cycle %0d", t);
    finishRun();
  end

  initial begin
    // R1: reset state
    tag = "R1";
    repeat (4) @(negedge clk);
    chk("R1", "strobe in reset", int'(countStrobe), 0);
    chk("R1", "noise in reset", int'(noiseError), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "strobe after reset", int'(countStrobe), 0);
    chk("R1", "dir after reset", int'(countUp), 0);
    settleClear();

    // R2: disabled pins produce neither counts nor noise
    tag = "R2";
    scaleMode = 2'd3;
    rotate(2, 1'b1);
    setAB(1, 1, 8);
    setAB(0, 0, 8);
    posNow = 0;
    tally("R2", 0, 0);
    chk("R2", "noise while disabled", int'(noiseError), 0);

    // R4: x4 decode
    tag = "R4";
    abEnable = 1'b1;
    settleClear();
    rotate(3, 1'b1);
    tally("R4", 12, 0);
    rotate(2, 1'b0);
    tally("R4", 0, 8);

    // R5: x2 decode
    tag = "R5";
    scaleMode = 2'd2;
    settleClear();
    rotate(2, 1'b1);
    tally("R5", 4, 0);
    rotate(1, 1'b0);
    tally("R5", 0, 2);

    // R6: x1 decode
    tag = "R6";
    scaleMode = 2'd1;
    settleClear();
    rotate(2, 1'b1);
    tally("R6", 2, 0);
    rotate(2, 1'b0);
    tally("R6", 0, 2);

    // R7: short glitch is filtered out
    tag = "R7";
    scaleMode = 2'd3;
    settleClear();
    setAB(1, 0, 2);
    setAB(0, 0, 8);
    setAB(0, 1, 1);
    setAB(0, 0, 8);
    tally("R7", 0, 0);

    // R8: illegal jump sets the sticky flag until cleared
    tag = "R8";
    setAB(1, 1, 10);
    posNow = 2;
    chk("R8", "noise set", int'(noiseError), 1);
    tally("R8", 0, 0);
    chk("R8", "noise held", int'(noiseError), 1);
    @(negedge clk); errClear = 1'b1;
    @(negedge clk); errClear = 1'b0;
    @(negedge clk);
    chk("R8", "noise cleared", int'(noiseError), 0);

    // R9 and R3: clock-and-direction mode
    tag = "R9";
    scaleMode = 2'd0;
    settleClear();
    setAB(0, 0, 8);
    setAB(1, 1, 8);
    setAB(0, 0, 8);
    chk("R9", "no noise in clkdir", int'(noiseError), 0);
    tag = "R3";
    settleClear();
    for (int i = 0; i < 3; i++) begin setAB(1, 1, 3); setAB(0, 1, 3); end
    tally("R3", 3, 0);
    for (int i = 0; i < 2; i++) begin setAB(1, 0, 2); setAB(0, 0, 2); end
    tally("R3", 0, 2);
    tag = "R2";
    abEnable = 1'b0;
    settleClear();
    for (int i = 0; i < 2; i++) begin setAB(1, 1, 3); setAB(0, 1, 3); end
    tally("R2", 0, 0);

    // R8: a clear coinciding with a new error keeps the flag set
    tag = "R8";
    abEnable = 1'b1;
    scaleMode = 2'd3;
    setAB(0, 0, 12);
    settleClear();
    setAB(1, 1, 1);
    repeat (5) @(negedge clk);
    errClear = 1'b1;
    @(negedge clk); errClear = 1'b0;
    @(negedge clk);
    chk("R8", "noise after coincident clear", int'(noiseError), int'(expN));
    repeat (10) @(negedge clk);

    finishRun();
  end
endmodule